// File: doc/BRIEF.md
# Byte-Code Driven SPI Sequencer

This block is a half-duplex SPI master that runs a small program instead of being driven one byte at a time by a host. The host writes up to eight one-byte opcodes, packed into a 64-bit program register, and the engine runs them in order. Opcodes select or release a chip select, shift out up to eight bytes, shift in up to eight bytes, jump back to an earlier slot while a loop count remains, and stop. Writing the program register starts execution at slot 0.

Data moves through two 64-bit holding registers, each with a full flag. The engine waits on a shift-out until the host has filled the transmit register. It waits on a shift-in until the host has emptied the receive register. Because of this handshake, a transfer longer than eight bytes is one looped program fed word by word. Mistimed host accesses and engine stalls set sticky error flags, and the host clears them by writing zero to the status register.

The host reaches every register through a simple word-wide register port. Reads are combinational. A read strobe is needed only for the receive register, because reading it has a side effect.

Top module: `spi_seq_engine`

## Requirements
- R1: After reset the status register reads 0x0001_0000_0000_0000 (idle state only), all `spi_cs_n` bits are high and `spi_sck` is low.
- R2: Writing the program register (index 0x7) while idle starts execution at slot 0. Slot 0 is bits 63:56 and each later slot is 8 bits lower. Opcode 0x00 (or any undefined opcode) stops the program, and so does finishing slot 7. A stop releases every chip select and returns to idle.
- R3: Opcode 0x1n with n in 1..NCS drives `spi_cs_n[n-1]` low and all other bits high. The select holds until another select opcode or a stop. Opcode 0x10 releases all chip selects.
- R4: Opcode 0x3n (n = 1..8) consumes the TX register (index 0x5) and sends its top n bytes, starting at bit 63, MSB first. Consuming TX clears status bit 59.
- R5: Opcode 0x4n (n = 1..8) shifts in n bytes. The RX register (index 0x6) then holds them right-justified, with the last byte in bits 7:0, and status bit 63 (RX full) is set.
- R6: Opcode 0xEn jumps to slot n while the loop count (counter register index 0x1, bits 39:32) is non-zero, and decrements the count. When the count is zero it falls through, so a count of L-1 runs the looped slots L times.
- R7: SCK follows SPI mode 0: it idles low, data is sampled on the rising edge and changed on the falling edge. Its period is 2 × (D + 1) clocks, where D is the divider in clock-register (index 0x3) bits 63:52.
- R8: A TX write sets status bit 59. A TX write while bit 59 is already set is dropped and sets bit 58 (TX overrun).
- R9: A shift-out reached while TX is empty sets bit 57 (TX underrun) and stalls with status state bit 51 until TX is written.
- R10: A shift-in reached while RX is full sets bit 62 (RX overrun) and stalls until RX is read.
- R11: A read of RX clears bit 63. A read of RX while bit 63 is clear sets bit 61 (RX underrun).
- R12: Status bits 55:48 show the one-hot engine state: 48 idle, 49 fetch, 50 shifting, 51 stalled. Writing zero to the status register (index 0x8) clears bits 57, 58, 61 and 62. A non-zero write has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effect on RX only) |
| reg_addr | input | 4 | Register index |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Combinational read data for `reg_addr` |
| spi_sck | output | 1 | SPI serial clock, mode 0 |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | NCS | Active-low chip selects |

## Verification
The assertions check the following on every cycle:
- At most one chip select is active, and none while idle.
- A shift never starts without TX data or without RX room.
- A TX write into an empty register always sets the full flag.
- A finished shift-in always sets RX full.
- SCK changes only on a divider tick.

Only the bench scenarios can show the rest:
- The bit order on the wire and the right-justified receive layout.
- The SCK period for a given divider.
- The number of passes of a counted branch.
- Stalls resuming after the host acts.
- A dropped write on overrun, and the flags clearing on a zero write to status.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;
    localparam int DATA_W = 64;
    localparam int SLOTS  = DATA_W / 8;
    localparam int PC_W   = $clog2(SLOTS);

    localparam logic [3:0] A_ERR  = 4'h0;
    localparam logic [3:0] A_CNT  = 4'h1;
    localparam logic [3:0] A_CLK  = 4'h3;
    localparam logic [3:0] A_TX   = 4'h5;
    localparam logic [3:0] A_RX   = 4'h6;
    localparam logic [3:0] A_SEQ  = 4'h7;
    localparam logic [3:0] A_STAT = 4'h8;

    localparam logic [3:0] OP_STOP = 4'h0;
    localparam logic [3:0] OP_SEL  = 4'h1;
    localparam logic [3:0] OP_OUT  = 4'h3;
    localparam logic [3:0] OP_IN   = 4'h4;
    localparam logic [3:0] OP_BR   = 4'hE;

    typedef enum logic [7:0] {
        ST_IDLE  = 8'h01,
        ST_FETCH = 8'h02,
        ST_SHIFT = 8'h04,
        ST_STALL = 8'h08
    } seq_state_e;
endpackage

// File: rtl/spi_clk_tick.sv
module spi_clk_tick #(
    parameter int DIV_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } tick_t;

    tick_t t_d, t_q;

    // one tick every div+1 enabled clocks = one SCK half period
    always_comb begin
        t_d  = t_q;
        tick = 1'b0;
        if (!en) begin
            t_d.cnt = '0;
        end else if (t_q.cnt >= div) begin
            t_d.cnt = '0;
            tick    = 1'b1;
        end else begin
            t_d.cnt = t_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    a_r7_tick_only_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> en);
endmodule

// File: rtl/spi_shifter.sv
module spi_shifter
    import spi_seq_pkg::*;
#(
    parameter int DIV_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              dir_out,
    input  logic [3:0]        nbytes,
    input  logic [DATA_W-1:0] load,
    input  logic [DIV_W-1:0]  div,
    input  logic              miso,
    output logic              busy,
    output logic              done,
    output logic              sck,
    output logic              mosi,
    output logic [DATA_W-1:0] sh_data
);
    localparam int BIT_W = $clog2(DATA_W + 1);

    typedef struct packed {
        logic              busy;
        logic              done;
        logic              sck;
        logic              dir_out;
        logic [BIT_W-1:0]  bits;
        logic [DATA_W-1:0] sh;
    } shf_t;

    shf_t s_d, s_q;
    logic tick;

    spi_clk_tick #(.DIV_W(DIV_W)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (s_q.busy),
        .div  (div),
        .tick (tick)
    );

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        if (!s_q.busy) begin
            if (start) begin
                s_d.busy    = 1'b1;
                s_d.sck     = 1'b0;
                s_d.dir_out = dir_out;
                s_d.bits    = BIT_W'({nbytes, 3'b000});
                s_d.sh      = dir_out ? load : '0;
            end
        end else if (tick) begin
            if (!s_q.sck) begin
                // rising edge: sample
                s_d.sck = 1'b1;
                if (!s_q.dir_out) s_d.sh = {s_q.sh[DATA_W-2:0], miso};
            end else begin
                // falling edge: advance
                s_d.sck  = 1'b0;
                if (s_q.dir_out) s_d.sh = {s_q.sh[DATA_W-2:0], 1'b0};
                s_d.bits = s_q.bits - 1'b1;
                if (s_q.bits == BIT_W'(1)) begin
                    s_d.busy = 1'b0;
                    s_d.done = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy    = s_q.busy;
    assign done    = s_q.done;
    assign sck     = s_q.sck;
    assign mosi    = s_q.busy & s_q.dir_out & s_q.sh[DATA_W-1];
    assign sh_data = s_q.sh;

    a_r7_sck_moves_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.busy && !tick) |=> $stable(sck));
    a_r7_sck_low_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sck);
endmodule

// File: rtl/spi_seq_engine.sv
module spi_seq_engine
    import spi_seq_pkg::*;
#(
    parameter int NCS    = 4,
    parameter int DIV_W  = 12,
    parameter int LOOP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [3:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              spi_sck,
    output logic              spi_mosi,
    input  logic              spi_miso,
    output logic [NCS-1:0]    spi_cs_n
);
    localparam logic [3:0] NCS_N    = 4'(NCS);
    localparam logic [PC_W-1:0] PC_LAST = PC_W'(SLOTS - 1);

    typedef struct packed {
        seq_state_e        st;
        logic [PC_W-1:0]   pc;
        logic [DATA_W-1:0] prog;
        logic [LOOP_W-1:0] loops;
        logic [DIV_W-1:0]  div;
        logic [DATA_W-1:0] tx;
        logic              tx_full;
        logic [DATA_W-1:0] rx;
        logic              rx_full;
        logic              tx_ovr;
        logic              tx_udr;
        logic              rx_ovr;
        logic              rx_udr;
        logic [3:0]        cs_sel;
        logic              shift_in;
    } eng_t;

    eng_t e_d, e_q;

    logic              sh_start, sh_dir_out, sh_busy, sh_done;
    logic [3:0]        sh_nbytes;
    logic [DATA_W-1:0] sh_data;
    logic [DATA_W-1:0] slot_w;
    logic [7:0]        op;
    logic [3:0]        nb;
    logic              go_next, go_stop;

    spi_shifter #(.DIV_W(DIV_W)) u_shifter (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (sh_start),
        .dir_out(sh_dir_out),
        .nbytes (sh_nbytes),
        .load   (e_q.tx),
        .div    (e_q.div),
        .miso   (spi_miso),
        .busy   (sh_busy),
        .done   (sh_done),
        .sck    (spi_sck),
        .mosi   (spi_mosi),
        .sh_data(sh_data)
    );

    always_comb begin
        e_d        = e_q;
        sh_start   = 1'b0;
        sh_dir_out = 1'b0;
        sh_nbytes  = '0;
        go_next    = 1'b0;
        go_stop    = 1'b0;
        slot_w     = e_q.prog << {e_q.pc, 3'b000};
        op         = slot_w[DATA_W-1 -: 8];
        nb         = (op[3:0] > 4'd8) ? 4'd8 : op[3:0];

        // ---- sequencer ----
        case (e_q.st)
            ST_FETCH, ST_STALL: begin
                case (op[7:4])
                    OP_SEL: begin
                        e_d.cs_sel = (op[3:0] <= NCS_N) ? op[3:0] : 4'd0;
                        go_next    = 1'b1;
                    end
                    OP_OUT: begin
                        if (nb == 4'd0) begin
                            go_next = 1'b1;
                        end else if (e_q.tx_full) begin
                            sh_start     = 1'b1;
                            sh_dir_out   = 1'b1;
                            sh_nbytes    = nb;
                            e_d.tx_full  = 1'b0;
                            e_d.shift_in = 1'b0;
                            e_d.st       = ST_SHIFT;
                        end else begin
                            e_d.tx_udr = 1'b1;
                            e_d.st     = ST_STALL;
                        end
                    end
                    OP_IN: begin
                        if (nb == 4'd0) begin
                            go_next = 1'b1;
                        end else if (!e_q.rx_full) begin
                            sh_start     = 1'b1;
                            sh_nbytes    = nb;
                            e_d.shift_in = 1'b1;
                            e_d.st       = ST_SHIFT;
                        end else begin
                            e_d.rx_ovr = 1'b1;
                            e_d.st     = ST_STALL;
                        end
                    end
                    OP_BR: begin
                        if (e_q.loops != '0) begin
                            e_d.loops = e_q.loops - 1'b1;
                            e_d.pc    = op[PC_W-1:0];
                            e_d.st    = ST_FETCH;
                        end else begin
                            go_next = 1'b1;
                        end
                    end
                    OP_STOP: go_stop = 1'b1;
                    default: go_stop = 1'b1;
                endcase
            end
            ST_SHIFT: begin
                if (sh_done) begin
                    if (e_q.shift_in) begin
                        e_d.rx      = sh_data;
                        e_d.rx_full = 1'b1;
                    end
                    go_next = 1'b1;
                end
            end
            default: ;
        endcase

        if (go_next) begin
            if (e_q.pc == PC_LAST) begin
                go_stop = 1'b1;
            end else begin
                e_d.pc = e_q.pc + 1'b1;
                e_d.st = ST_FETCH;
            end
        end
        if (go_stop) begin
            e_d.st     = ST_IDLE;
            e_d.pc     = '0;
            e_d.cs_sel = 4'd0;
        end

        // ---- host register port ----
        if (reg_wr) begin
            case (reg_addr)
                A_CNT:  e_d.loops = reg_wdata[32 +: LOOP_W];
                A_CLK:  e_d.div   = reg_wdata[DATA_W-1 -: DIV_W];
                A_TX: begin
                    if (e_q.tx_full) begin
                        e_d.tx_ovr = 1'b1;
                    end else begin
                        e_d.tx      = reg_wdata;
                        e_d.tx_full = 1'b1;
                    end
                end
                A_SEQ: begin
                    if (e_q.st == ST_IDLE) begin
                        e_d.prog = reg_wdata;
                        e_d.pc   = '0;
                        e_d.st   = ST_FETCH;
                    end
                end
                A_STAT: begin
                    if (reg_wdata == '0) begin
                        e_d.tx_ovr = 1'b0;
                        e_d.tx_udr = 1'b0;
                        e_d.rx_ovr = 1'b0;
                        e_d.rx_udr = 1'b0;
                    end
                end
                default: ;
            endcase
        end
        if (reg_rd && (reg_addr == A_RX)) begin
            if (e_q.rx_full) e_d.rx_full = 1'b0;
            else             e_d.rx_udr  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            e_q    <= '0;
            e_q.st <= ST_IDLE;
        end else begin
            e_q <= e_d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_ERR:  reg_rdata = '0;
            A_CNT:  reg_rdata[32 +: LOOP_W] = e_q.loops;
            A_CLK:  reg_rdata[DATA_W-1 -: DIV_W] = e_q.div;
            A_TX:   reg_rdata = e_q.tx;
            A_RX:   reg_rdata = e_q.rx;
            A_SEQ:  reg_rdata = e_q.prog;
            A_STAT: begin
                reg_rdata[63]    = e_q.rx_full;
                reg_rdata[62]    = e_q.rx_ovr;
                reg_rdata[61]    = e_q.rx_udr;
                reg_rdata[59]    = e_q.tx_full;
                reg_rdata[58]    = e_q.tx_ovr;
                reg_rdata[57]    = e_q.tx_udr;
                reg_rdata[55:48] = e_q.st;
            end
            default: ;
        endcase
    end

    for (genvar i = 0; i < NCS; i++) begin : g_cs
        assign spi_cs_n[i] = (e_q.cs_sel != 4'(i + 1));
    end

    a_r3_cs_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~spi_cs_n));
    a_r2_idle_releases_cs: assert property (@(posedge clk) disable iff (!rst_n)
        (e_q.st == ST_IDLE) |-> (&spi_cs_n));
    a_r4_out_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_start && sh_dir_out) |-> (e_q.tx_full && !sh_busy));
    a_r10_in_needs_room: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_start && !sh_dir_out) |-> !e_q.rx_full);
    a_r8_tx_write_fills: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_TX && !e_q.tx_full) |=> e_q.tx_full);
    a_r5_in_done_fills_rx: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_done && e_q.shift_in) |=> e_q.rx_full);
endmodule

// File: tb/spi_seq_engine_bench.sv
module spi_seq_engine_bench;
    import spi_seq_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NCS = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              reg_wr = 1'b0;
    logic              reg_rd = 1'b0;
    logic [3:0]        reg_addr = 4'h0;
    logic [63:0]       reg_wdata = '0;
    logic [63:0]       reg_rdata;
    logic              spi_sck, spi_mosi, spi_miso;
    logic [NCS-1:0]    spi_cs_n;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_seq_engine #(.NCS(NCS)) u_spi_seq_engine (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
        .spi_cs_n(spi_cs_n)
    );

    // ---- mode 0 slave model ----
    logic        slv_load = 1'b0;
    logic        slv_clr  = 1'b0;
    logic [63:0] slv_seed = '0;
    logic [63:0] slv_src, slv_cap;
    int          rise_cnt;
    longint      t_prev, t_last;

    assign spi_miso = slv_src[63];

    always @(negedge spi_sck or posedge slv_load) begin
        if (slv_load) slv_src <= slv_seed;
        else          slv_src <= {slv_src[62:0], 1'b0};
    end

    always @(posedge spi_sck or posedge slv_clr) begin
        if (slv_clr) begin
            slv_cap  <= '0;
            rise_cnt <= 0;
            t_prev   <= 0;
            t_last   <= 0;
        end else begin
            slv_cap  <= {slv_cap[62:0], spi_mosi};
            rise_cnt <= rise_cnt + 1;
            t_prev   <= t_last;
            t_last   <= $time;
        end
    end

    // ---- helpers ----
    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [63:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic peek(input logic [3:0] a, output logic [63:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic rd_rx(output logic [63:0] v);
        @(negedge clk);
        reg_addr = A_RX; reg_rd = 1'b1;
        #1 v = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic slave_prep(input logic [63:0] seed);
        @(negedge clk);
        slv_seed = seed; slv_load = 1'b1; slv_clr = 1'b1;
        #1 slv_load = 1'b0; slv_clr = 1'b0;
    endtask

    task automatic wait_idle(input string req);
        logic [63:0] s;
        int n = 0;
        s = '0;
        while (n < 5000) begin
            peek(A_STAT, s);
            if (s[55:48] == 8'h01) break;
            n++;
        end
        if (n >= 5000) chk({req, " idle timeout"}, s, 64'h0001_0000_0000_0000);
    endtask

    task automatic wait_tx_free();
        logic [63:0] s;
        s = 64'h0800_0000_0000_0000;
        for (int n = 0; n < 5000 && s[59]; n++) peek(A_STAT, s);
    endtask

    // ---- vector table: shift-out bytes, shift-in bytes, divider, tx, slave data ----
    typedef struct packed {
        logic [3:0]  n_out;
        logic [3:0]  n_in;
        logic [11:0] div;
        logic [63:0] tx;
        logic [63:0] src;
    } vec_t;

    localparam int NVEC = 6;
    localparam vec_t VECS [NVEC] = '{
        '{4'd1, 4'd0, 12'd0, 64'hA5A5_0000_1111_2222, 64'h0},
        '{4'd2, 4'd2, 12'd1, 64'h1234_5678_9ABC_DEF0, 64'hFFFF_C0DE_0000_0000},
        '{4'd8, 4'd0, 12'd2, 64'h0123_4567_89AB_CDEF, 64'h0},
        '{4'd1, 4'd7, 12'd0, 64'h8100_0000_0000_0000, 64'h77A1_B2C3_D4E5_F607},
        '{4'd3, 4'd5, 12'd4, 64'hF0E1_D2C3_B4A5_9687, 64'h0102_0304_0506_0708},
        '{4'd4, 4'd4, 12'd3, 64'hDEAD_BEEF_CAFE_F00D, 64'h5555_AAAA_3C3C_C3C3}
    };

    initial begin
        logic [63:0] v, exp_cap, exp_rx, prog;
        logic [7:0]  in_op;
        int n, m;
        v = '0;

        slave_prep(64'h0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        peek(A_STAT, v);
        chk("R1 status", v, 64'h0001_0000_0000_0000);
        chk("R1 cs_n", {60'h0, spi_cs_n}, 64'hF);
        chk("R1 sck", {63'h0, spi_sck}, 64'h0);

        // vector walk: R4 R5 R7 R2
        for (int i = 0; i < NVEC; i++) begin
            n = int'(VECS[i].n_out);
            m = int'(VECS[i].n_in);
            in_op = (m > 0) ? (8'h40 | {4'h0, VECS[i].n_in}) : 8'h10;
            prog = {8'h11, 8'h30 | {4'h0, VECS[i].n_out}, in_op, 8'h10, 32'h0};
            slave_prep(VECS[i].src);
            wr(A_CLK, {VECS[i].div, 52'h0});
            wr(A_TX, VECS[i].tx);
            wr(A_SEQ, prog);
            wait_idle("R2 vector");
            exp_cap = (VECS[i].tx >> (64 - 8*n)) << (8*m);
            chk("R4 mosi bytes", slv_cap, exp_cap);
            chk("R7 sck edges", 64'(rise_cnt), 64'(8*(n+m)));
            chk("R2 cs released", {60'h0, spi_cs_n}, 64'hF);
            peek(A_STAT, v);
            chk("R4 tx consumed", {63'h0, v[59]}, 64'h0);
            if (m > 0) begin
                exp_rx = (VECS[i].src << (8*n)) >> (64 - 8*m);
                rd_rx(v);
                chk("R5 rx right-justified", v, exp_rx);
            end
            if (i == NVEC-1)
                chk("R7 sck period", 64'(t_last - t_prev), 64'(2*(3+1)*CLK_PERIOD));
        end

        // R8 TX overrun: second write dropped
        wr(A_CLK, 64'h0);
        wr(A_TX, 64'h1111_2222_3333_4444);
        peek(A_STAT, v);
        chk("R8 tx full", {63'h0, v[59]}, 64'h1);
        wr(A_TX, 64'h9999_8888_7777_6666);
        peek(A_STAT, v);
        chk("R8 tx overrun", {63'h0, v[58]}, 64'h1);
        slave_prep(64'h0);
        wr(A_SEQ, {8'h11, 8'h38, 48'h0});
        wait_idle("R8");
        chk("R8 first word kept", slv_cap, 64'h1111_2222_3333_4444);
        wr(A_STAT, 64'h0);
        peek(A_STAT, v);
        chk("R12 clear to idle", v, 64'h0001_0000_0000_0000);

        // R9 TX underrun stall, R3 select
        slave_prep(64'h0);
        wr(A_SEQ, {8'h11, 8'h32, 8'h10, 40'h0});
        repeat (10) @(negedge clk);
        peek(A_STAT, v);
        chk("R9 tx underrun", {63'h0, v[57]}, 64'h1);
        chk("R9 stalled state", {56'h0, v[55:48]}, 64'h08);
        chk("R3 cs1 active", {60'h0, spi_cs_n}, 64'hE);
        chk("R9 no sck while stalled", 64'(rise_cnt), 64'h0);
        wr(A_TX, 64'hBEEF_0000_0000_0000);
        wait_idle("R9");
        chk("R9 resumes", slv_cap, 64'hBEEF);
        wr(A_STAT, 64'h0);

        // R6 counted branch: three passes of slot 1
        slave_prep(64'h0);
        wr(A_CNT, 64'h0000_0002_0000_0000);
        wr(A_SEQ, {8'h12, 8'h38, 8'hE1, 8'h10, 32'h0});
        repeat (5) @(negedge clk);
        chk("R3 cs2 active", {60'h0, spi_cs_n}, 64'hD);
        for (int k = 0; k < 3; k++) begin
            wait_tx_free();
            wr(A_TX, 64'h0101_0101_0101_0101 * 64'(k + 1));
        end
        wait_idle("R6");
        chk("R6 three passes", 64'(rise_cnt), 64'd192);
        chk("R6 last word", slv_cap, 64'h0303_0303_0303_0303);
        peek(A_CNT, v);
        chk("R6 count spent", v, 64'h0);
        wr(A_STAT, 64'h0);

        // R10 RX overrun stall
        slave_prep(64'hC35A_F000_0000_0000);
        wr(A_SEQ, {8'h11, 8'h41, 8'h42, 8'h10, 32'h0});
        repeat (80) @(negedge clk);
        peek(A_STAT, v);
        chk("R10 rx overrun", {63'h0, v[62]}, 64'h1);
        chk("R10 stalled", {56'h0, v[55:48]}, 64'h08);
        chk("R5 rx full", {63'h0, v[63]}, 64'h1);
        rd_rx(v);
        chk("R10 first byte", v, 64'hC3);
        wait_idle("R10");
        rd_rx(v);
        chk("R10 after resume", v, 64'h5AF0);
        peek(A_STAT, v);
        chk("R11 rx full cleared", {63'h0, v[63]}, 64'h0);
        chk("R11 no underrun yet", {63'h0, v[61]}, 64'h0);

        // R11 RX underrun and R12 clear rules
        rd_rx(v);
        peek(A_STAT, v);
        chk("R11 rx underrun", {63'h0, v[61]}, 64'h1);
        wr(A_STAT, 64'h1);
        peek(A_STAT, v);
        chk("R12 nonzero write ignored", {63'h0, v[61]}, 64'h1);
        wr(A_STAT, 64'h0);
        peek(A_STAT, v);
        chk("R12 zero write clears", v, 64'h0001_0000_0000_0000);

        // R2 stop opcode: slot 2 never runs
        slave_prep(64'h0);
        wr(A_TX, 64'h7777_0000_0000_0000);
        wr(A_SEQ, {8'h12, 8'h00, 8'h31, 40'h0});
        wait_idle("R2 stop");
        peek(A_STAT, v);
        chk("R2 stop leaves tx", {63'h0, v[59]}, 64'h1);
        chk("R2 stop no sck", 64'(rise_cnt), 64'h0);
        chk("R2 stop releases cs", {60'h0, spi_cs_n}, 64'hF);

        // R2 past slot 7 ends program
        wr(A_SEQ, 64'h1110_1110_1110_1112);
        wait_idle("R2 end");
        chk("R2 end releases cs", {60'h0, spi_cs_n}, 64'hF);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog act=running exp=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule